// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Decoder

This block sits behind the clock and data recovery stage of a receive line port. It takes the recovered dual-rail symbols, one rail for positive marks and one for negative marks, and turns them into a single-rail data stream. Mode `mode_hdb3` picks the substitution code. When it is low, the three-zero code used at the DS3 and STS-1 rates is decoded. When it is high, the four-zero code used at the E3 rate is decoded. Each recognised substitution group is replaced by zeros. A short look-ahead pipeline lets the block blank marks that arrived before the violation that identifies the group.

Each symbol is qualified by a one-clock strobe `bit_en`. Line-code problems are reported on `lcv_out` as a single-clock high pulse. The problems are a bipolar violation that fits no substitution group, an over-long string of zeros, and a symbol with both rails set. With `nrz_bypass` high, the decoder is skipped and the positive rail is passed through as NRZ data. The code mode should be changed only while reset is held.

Top module: `lb_line_decoder`

## Requirements
- R1: With `mode_hdb3`=0, a group `0 0 V` or `B 0 V` (B a mark alternating from the previous mark, V a mark of the same polarity as the mark before it) is decoded as three zeros and raises no `lcv_out`.
- R2: With `mode_hdb3`=1, a group `0 0 0 V` or `B 0 0 V` is decoded as four zeros and raises no `lcv_out`.
- R3: A positive mark (`pos_in`=1, `neg_in`=0) or a negative mark (`pos_in`=0, `neg_in`=1) decodes to 1 and a zero symbol (both low) decodes to 0. The bit sampled at strobe j appears on `dat_out` right after strobe j+3 (code mode 0) or j+4 (code mode 1).
- R4: A bipolar violation that fits no substitution group of the selected code raises `lcv_out` for that symbol.
- R5: With `mode_hdb3`=0, every zero symbol that brings the current run of consecutive zero symbols to 3 or more raises `lcv_out`.
- R6: With `mode_hdb3`=1, every zero symbol that brings the current run of consecutive zero symbols to 4 or more raises `lcv_out`.
- R7: A symbol with both rails high raises `lcv_out`, decodes to 1, and leaves the remembered polarity of the last mark unchanged.
- R8: The remembered polarity of the last mark is updated by every mark, including the V of a substitution group, so a following mark of the same polarity as that V is a violation.
- R9: With `nrz_bypass`=1, `dat_out` takes the value of `pos_in` one strobe later and `lcv_out` stays low.
- R10: `lcv_out` is high for exactly the clock after a strobe. Without a strobe, `dat_out` holds its value and `lcv_out` is low.
- R11: Synchronous reset drives `dat_out` and `lcv_out` low and clears the polarity memory, so the first mark after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Symbol strobe, one clock per received bit |
| pos_in | input | 1 | Positive-mark rail, or NRZ data in bypass |
| neg_in | input | 1 | Negative-mark rail |
| mode_hdb3 | input | 1 | 0: three-zero code, 1: four-zero code |
| nrz_bypass | input | 1 | 1: pass `pos_in` straight through, no checking |
| dat_out | output | 1 | Decoded single-rail data |
| lcv_out | output | 1 | One-clock line-code-violation pulse |

## Verification
The bench generates random data and encodes it in the bench with each substitution code. Parity-driven choice between the two group shapes makes both shapes occur, and dense zeros make substitutions frequent. These streams show whether the decoder blanks the correct number of bits without any false violation. Directed symbol strings then cover the cases that separate a valid group from a stray violation: a violation preceded by too few zeros, a same-polarity mark straight after a substitution's V, both rails high followed by a mark of the old polarity, and zero runs one short of and at the limit. A bypass pass with zero runs and double-rail symbols confirms that checking is switched off and that the latency drops to one strobe.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int B3_SPAN = 3;              // group length, three-zero code
  localparam int H3_SPAN = 4;              // group length, four-zero code
  localparam int LOOK    = H3_SPAN - 2;    // raw-mark history needed for the fit test

  typedef struct packed {
    logic mark;   // any rail active
    logic both;   // both rails active
    logic neg;    // negative polarity mark
  } lb_sym_t;

  function automatic int span_of(input logic hdb3);
    return hdb3 ? H3_SPAN : B3_SPAN;
  endfunction
endpackage

// File: rtl/lb_sym_classify.sv
module lb_sym_classify
  import lb_pkg::*;
(
  input  logic    pos_in,
  input  logic    neg_in,
  output lb_sym_t sym
);
  always_comb begin
    sym.mark = pos_in | neg_in;
    sym.both = pos_in & neg_in;
    sym.neg  = neg_in & ~pos_in;
  end
endmodule

// File: rtl/lb_zero_run.sv
module lb_zero_run
  import lb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic is_mark,
  input  logic hdb3,
  output logic run_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit   = hdb3 ? CNT_W'(H3_SPAN) : CNT_W'(B3_SPAN);
    cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);
    run_hit = !is_mark && (cnt_nxt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (bit_en) cnt <= is_mark ? '0 : cnt_nxt;
  end

  // R5
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && is_mark) |=> (cnt == '0));
endmodule

// File: rtl/lb_subst_detect.sv
module lb_subst_detect
  import lb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bit_en,
  input  lb_sym_t sym,
  input  logic    hdb3,
  output logic    sub_hit,
  output logic    bad_viol
);
  logic [LOOK-1:0] rm;        // raw mark history, rm[0] most recent
  logic            last_neg;
  logic            have_mark;
  logic            bpv;
  logic            fits;

  always_comb begin
    bpv      = sym.mark && !sym.both && have_mark && (sym.neg == last_neg);
    fits     = hdb3 ? (!rm[0] && !rm[1]) : !rm[0];
    sub_hit  = bpv && fits;
    bad_viol = bpv && !fits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rm        <= '0;
      last_neg  <= 1'b0;
      have_mark <= 1'b0;
    end else if (bit_en) begin
      rm <= {rm[LOOK-2:0], sym.mark};
      if (sym.mark && !sym.both) begin
        last_neg  <= sym.neg;
        have_mark <= 1'b1;
      end
    end
  end

  // R8
  pol_track_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && sym.mark && !sym.both) |=> (have_mark && last_neg == $past(sym.neg)));

  // R7
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && sym.both) |=> $stable(last_neg));
endmodule

// File: rtl/lb_data_pipe.sv
module lb_data_pipe
  import lb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic hdb3,
  input  logic new_bit,
  input  logic clr,
  output logic tail_bit
);
  localparam int DEPTH = H3_SPAN;

  logic [DEPTH-1:0] d;
  logic [DEPTH-1:0] wipe;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_comb wipe[i] = clr && (i < span_of(hdb3));
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)         d[0] <= 1'b0;
          else if (bit_en) d[0] <= wipe[0] ? 1'b0 : new_bit;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)         d[i] <= 1'b0;
          else if (bit_en) d[i] <= wipe[i] ? 1'b0 : d[i-1];
        end
      end
    end
  endgenerate

  always_comb tail_bit = hdb3 ? d[H3_SPAN-1] : d[B3_SPAN-1];

  // R1
  blank_group_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && clr) |=> (d[B3_SPAN-1:0] == '0));
endmodule

// File: rtl/lb_line_decoder.sv
module lb_line_decoder
  import lb_pkg::*;
#(
  parameter int RUN_CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic pos_in,
  input  logic neg_in,
  input  logic mode_hdb3,
  input  logic nrz_bypass,
  output logic dat_out,
  output logic lcv_out
);
  lb_sym_t sym;
  logic    run_hit;
  logic    sub_hit;
  logic    bad_viol;
  logic    tail_bit;

  lb_sym_classify u_cls (
    .pos_in (pos_in),
    .neg_in (neg_in),
    .sym    (sym)
  );

  lb_zero_run #(.CNT_W(RUN_CNT_W)) u_run (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .is_mark (sym.mark),
    .hdb3    (mode_hdb3),
    .run_hit (run_hit)
  );

  lb_subst_detect u_det (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .sym      (sym),
    .hdb3     (mode_hdb3),
    .sub_hit  (sub_hit),
    .bad_viol (bad_viol)
  );

  lb_data_pipe u_pipe (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .hdb3     (mode_hdb3),
    .new_bit  (sym.mark && !sub_hit),
    .clr      (sub_hit),
    .tail_bit (tail_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_out <= 1'b0;
      lcv_out <= 1'b0;
    end else begin
      lcv_out <= bit_en && !nrz_bypass && (sym.both || bad_viol || run_hit);
      if (bit_en) dat_out <= nrz_bypass ? pos_in : tail_bit;
    end
  end

  // R9
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lcv_out |-> !$past(nrz_bypass));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> ($stable(dat_out) && !lcv_out));

  // R7
  both_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && pos_in && neg_in && !nrz_bypass) |=> lcv_out);
endmodule

// File: tb/sim_lb_line_decoder.sv
module sim_lb_line_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic pos_in = 1'b0;
  logic neg_in = 1'b0;
  logic mode_hdb3 = 1'b0;
  logic nrz_bypass = 1'b0;
  logic dat_out;
  logic lcv_out;

  always #10 clk = ~clk;   // 50 MHz

  lb_line_decoder u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pos_in(pos_in), .neg_in(neg_in),
    .mode_hdb3(mode_hdb3), .nrz_bypass(nrz_bypass),
    .dat_out(dat_out), .lcv_out(lcv_out)
  );

  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;
  int  seq_len;
  int  sym_q [0:599];   // 0 zero, 1 positive, 2 negative, 3 both rails
  bit  edat  [0:599];
  bit  elcv  [0:599];
  bit  rdata [0:599];

  task automatic check(input string msg, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic do_reset(input bit hdb3, input bit byp);
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
    mode_hdb3 = hdb3; nrz_bypass = byp;
    repeat (3) @(negedge clk);
    check("R11 dat_out after reset", int'(dat_out), 0);
    check("R11 lcv_out after reset", int'(lcv_out), 0);
    rst = 1'b0;
  endtask

  task automatic load(input string s, input string d, input string l);
    seq_len = s.len();
    for (int i = 0; i < seq_len; i++) begin
      case (s[i])
        "+": sym_q[i] = 1;
        "-": sym_q[i] = 2;
        "B": sym_q[i] = 3;
        default: sym_q[i] = 0;
      endcase
      edat[i] = (d[i] == "1");
      elcv[i] = (l[i] == "1");
    end
  endtask

  // Encoder built from the code rules: parity of marks since last V picks the group shape.
  task automatic encode(input bit hdb3, input int n);
    int span, p, ones, i;
    bit allz;
    span = hdb3 ? 4 : 3; p = -1; ones = 0; i = 0;
    while (i < n) begin
      allz = (i + span <= n);
      for (int j = 0; j < span; j++) if (allz && rdata[i+j]) allz = 0;
      if (allz) begin
        for (int j = 0; j < span; j++) sym_q[i+j] = 0;
        if (ones % 2 == 0) begin
          p = -p;
          sym_q[i] = (p > 0) ? 1 : 2;
        end
        sym_q[i+span-1] = (p > 0) ? 1 : 2;
        ones = 0; i += span;
      end else if (rdata[i]) begin
        p = -p; sym_q[i] = (p > 0) ? 1 : 2; ones++; i++;
      end else begin
        sym_q[i] = 0; i++;
      end
    end
    for (int k = 0; k < n; k++) begin edat[k] = rdata[k]; elcv[k] = 0; end
    seq_len = n;
  endtask

  task automatic run_stream(input bit hdb3, input bit byp, input bit gaps, input string tag);
    int span, g;
    logic held;
    span = hdb3 ? 4 : 3;
    do_reset(hdb3, byp);
    for (int k = 0; k < seq_len; k++) begin
      g = gaps ? int'($urandom % 3) : 0;
      for (int q = 0; q < g; q++) begin
        bit_en = 1'b0;
        held = dat_out;
        @(negedge clk);
        check({tag, " R10 lcv_out idle"}, int'(lcv_out), 0);
        check({tag, " R10 dat_out held"}, int'(dat_out), int'(held));
      end
      pos_in = (sym_q[k] == 1) || (sym_q[k] == 3);
      neg_in = (sym_q[k] == 2) || (sym_q[k] == 3);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      if (byp) begin
        check({tag, " R9 lcv_out"}, int'(lcv_out), 0);
        check({tag, " R9 dat_out"}, int'(dat_out), int'(sym_q[k] == 1 || sym_q[k] == 3));
      end else begin
        check({tag, " lcv_out"}, int'(lcv_out), int'(elcv[k]));
        if (k >= span) check({tag, " R3 dat_out"}, int'(dat_out), int'(edat[k-span]));
      end
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'd1207));
    // R1 B0V group, code mode 0
    load("+0+-+-+", "0001111", "0000000");          run_stream(0, 0, 0, "R1 B0V");
    // R4 adjacent same-polarity marks, code mode 0
    load("++-+-+", "111111", "010000");             run_stream(0, 0, 0, "R4 stray");
    // R7 both rails, polarity kept; R11 first mark after reset not flagged
    load("+B+-+-", "111111", "011000");             run_stream(0, 0, 0, "R7 R11 both");
    // R5 zero run, code mode 0
    load("+0000-+-", "10000111", "00011000");       run_stream(0, 0, 0, "R5 zeros");
    // R8 mark after V of the same polarity, plus R1 00V group
    load("+00++-+-", "10001111", "00001000");       run_stream(0, 0, 0, "R8 R1 00V");
    // R6 zero run, code mode 1
    load("+0000-+-+", "100001111", "000010000");    run_stream(1, 0, 0, "R6 zeros");
    // R4 violation with too few zeros for code mode 1
    load("+0+-+-+-", "10111111", "00100000");       run_stream(1, 0, 0, "R4 short");
    // R2 B00V group
    load("+00+-+-+-+", "0000111111", "0000000000"); run_stream(1, 0, 0, "R2 B00V");
    // R2 000V group
    load("-000-+-+-", "100001111", "000000000");    run_stream(1, 0, 0, "R2 000V");
    // R9 bypass with zero runs and double-rail symbols
    load("00000B+-B+", "0000011011", "0000000000"); run_stream(0, 1, 0, "R9 bypass");
    // Random encoded streams, both codes
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 300; k++) rdata[k] = ($urandom % 3 == 0);
      encode(m[0], 300);
      run_stream(m[0], 0, 1, m[0] ? "R2 R3 random" : "R1 R3 random");
    end
    // Random bypass symbols
    for (int k = 0; k < 60; k++) sym_q[k] = int'($urandom % 4);
    seq_len = 60;
    run_stream(1, 1, 1, "R9 random");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule